// File: doc/BRIEF.md
# Cascadable Vectored Interrupt Controller

This controller watches up to 32 level-sensitive request lines. Software programs each line with a priority level, a register-set number, a non-maskable flag and an enable bit through a small memory-mapped slave port. A software-interrupt register can raise any line as if its hardware wire were high.

Every cycle the controller picks the strongest active local line. It then compares that line with a record arriving on a chain input. It registers the stronger of the two onto its output record. The output record carries a computed 32-bit handler address, the register set, the NMI flag and the level.

The chain input and the output use the same record format. Several controllers can therefore be cascaded to serve more than 32 lines, with the last output going to the processor. The output is valid on every cycle and has no back-pressure.

Top module: `vic_chain_node`

## Requirements
- R1: After reset the output record is all zero, and every line is disabled, with level 0, register set 0 and NMI 0. The software-interrupt register, vector base and spacing code are also zero.
- R2: The output record is 45 bits. It holds the handler address in [44:13], the register set in [12:7], the NMI flag in [6] and the level in [5:0]. A level of 0 means that no interrupt is requested.
- R3: A line is active when its wire or its software-interrupt bit is 1, its enable bit is 1 and its level is nonzero. Among the active lines the local winner has the highest level, and a tie goes to the lowest line index.
- R4: An active line with its NMI flag set beats every active line without it, whatever the levels. Among NMI lines, rule R3 applies.
- R5: The local winner replaces the chain record only when its priority key is strictly greater than the chain's key. The key is {NMI, level}, and it is 0 when the level is 0. Otherwise the chain record is forwarded bit for bit.
- R6: The winner's handler address is vector base + index × spacing. Spacing codes 0, 1, 2 and 3 select 16, 32, 64 and 128 bytes.
- R7: The output is registered. A change at the inputs appears on the output exactly one clock later.
- R8: A line whose enable bit is 0 never affects the output, whatever its wire or level.
- R9: Writing address 0x20 loads the software-interrupt register, one bit per line. A set bit acts exactly like a high wire on that line.
- R10: A write takes effect at the clock edge where it is sampled, with no wait cycle. A read samples at its clock edge, and csr_rdata holds the value from the following cycle until the next read.
- R11: Register map:
  - Address i (i < 32) is line i's configuration: [5:0] level, [11:6] register set, [12] NMI, [13] enable.
  - 0x20 is the software-interrupt register.
  - 0x21 is the vector base.
  - 0x22 holds the spacing code in [1:0].
  - Unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 32 | Level-sensitive request lines |
| csr_rd | input | 1 | Register read strobe |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 6 | Register address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid one cycle after the read |
| chain_in | input | 45 | Record from the upstream controller |
| chain_out | output | 45 | Registered interrupt record |

## Verification
Every piece of internal state ends up in the output record one clock after it matters, so a fault shows as a wrong field on chain_out on the next cycle. A wrong stored level or enable bit picks the wrong line. A bad base or spacing moves the handler address. A broken key comparison either drops a chain request or overrides it. Register corruption is also visible directly through readback one cycle after a read. Random traffic on the lines and on the chain input, with regular reprogramming, exposes a fault within a few cycles of the state being used.

// File: rtl/vic_chain_node.sv
module vic_chain_node #(
  parameter int NUM_IRQ = 32,
  parameter int LVL_W   = 6,
  parameter int RS_W    = 6,
  parameter int HA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_IRQ-1:0]            irq_in,
  input  logic                          csr_rd,
  input  logic                          csr_wr,
  input  logic [5:0]                    csr_addr,
  input  logic [31:0]                   csr_wdata,
  output logic [31:0]                   csr_rdata,
  input  logic [HA_W+RS_W+LVL_W:0]      chain_in,
  output logic [HA_W+RS_W+LVL_W:0]      chain_out
);
  localparam int REC_W = HA_W + RS_W + LVL_W + 1;
  localparam int KEY_W = LVL_W + 1;
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [5:0] A_SWI   = 6'h20;
  localparam logic [5:0] A_BASE  = 6'h21;
  localparam logic [5:0] A_SPACE = 6'h22;

  logic [LVL_W-1:0] lvl_q [NUM_IRQ];
  logic [RS_W-1:0]  rs_q  [NUM_IRQ];
  logic [NUM_IRQ-1:0] nmi_q, en_q, swi_q, act;
  logic [HA_W-1:0]  base_q;
  logic [1:0]       space_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        lvl_q[i] <= '0;
        rs_q[i]  <= '0;
      end
      nmi_q   <= '0;
      en_q    <= '0;
      swi_q   <= '0;
      base_q  <= '0;
      space_q <= '0;
    end else if (csr_wr) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (csr_addr == 6'(i)) begin
          lvl_q[i] <= csr_wdata[LVL_W-1:0];
          rs_q[i]  <= csr_wdata[LVL_W +: RS_W];
          nmi_q[i] <= csr_wdata[LVL_W+RS_W];
          en_q[i]  <= csr_wdata[LVL_W+RS_W+1];
        end
      end
      if (csr_addr == A_SWI)   swi_q   <= csr_wdata[NUM_IRQ-1:0];
      if (csr_addr == A_BASE)  base_q  <= csr_wdata[HA_W-1:0];
      if (csr_addr == A_SPACE) space_q <= csr_wdata[1:0];
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (csr_addr == 6'(i)) rd_mux = 32'({en_q[i], nmi_q[i], rs_q[i], lvl_q[i]});
    if (csr_addr == A_SWI)   rd_mux = 32'(swi_q);
    if (csr_addr == A_BASE)  rd_mux = 32'(base_q);
    if (csr_addr == A_SPACE) rd_mux = 32'(space_q);
  end

  always_ff @(posedge clk) begin
    if (rst)         csr_rdata <= '0;
    else if (csr_rd) csr_rdata <= rd_mux;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_act
    assign act[g] = (irq_in[g] | swi_q[g]) & en_q[g] & (lvl_q[g] != '0);
  end

  logic [KEY_W-1:0] best_key;
  logic [IDX_W-1:0] best_idx;
  always_comb begin
    best_key = '0;
    best_idx = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (act[i] && {nmi_q[i], lvl_q[i]} > best_key) begin
        best_key = {nmi_q[i], lvl_q[i]};
        best_idx = i[IDX_W-1:0];
      end
  end

  logic [2:0]       shamt;
  logic [HA_W-1:0]  handler;
  logic [KEY_W-1:0] chain_key;
  logic [REC_W-1:0] local_rec;

  assign shamt     = 3'd4 + {1'b0, space_q};
  assign handler   = base_q + (HA_W'(best_idx) << shamt);
  assign local_rec = {handler, rs_q[best_idx], nmi_q[best_idx], lvl_q[best_idx]};
  assign chain_key = (chain_in[LVL_W-1:0] == '0) ? '0 : chain_in[LVL_W:0];

  always_ff @(posedge clk) begin
    if (rst) chain_out <= '0;
    else     chain_out <= (best_key > chain_key) ? local_rec : chain_in;
  end
endmodule

// File: rtl/vic_chain_node_chk.sv
module vic_chain_node_chk #(
  parameter int NUM_IRQ = 32,
  parameter int LVL_W   = 6,
  parameter int RS_W    = 6,
  parameter int HA_W    = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     csr_wr,
  input logic [5:0]               csr_addr,
  input logic [31:0]              csr_wdata,
  input logic [HA_W+RS_W+LVL_W:0] chain_in,
  input logic [HA_W+RS_W+LVL_W:0] chain_out,
  input logic [NUM_IRQ-1:0]       act,
  input logic [HA_W-1:0]          base_q,
  input logic [NUM_IRQ-1:0]       swi_q
);
  function automatic logic [LVL_W:0] key_of(logic [HA_W+RS_W+LVL_W:0] r);
    return (r[LVL_W-1:0] == '0) ? '0 : r[LVL_W:0];
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> chain_out == '0);

  assert_chain_floor_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> key_of(chain_out) >= $past(key_of(chain_in)));

  assert_idle_output_R8: assert property (@(posedge clk) disable iff (rst)
    (chain_in[LVL_W-1:0] == '0 && act == '0) |=> chain_out[LVL_W-1:0] == '0);

  assert_base_write_R10: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && csr_addr == 6'h21) |=> base_q == $past(csr_wdata[HA_W-1:0]));

  assert_swi_write_R9: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && csr_addr == 6'h20) |=> swi_q == $past(csr_wdata[NUM_IRQ-1:0]));
endmodule

bind vic_chain_node vic_chain_node_chk #(
  .NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W), .RS_W(RS_W), .HA_W(HA_W)
) u_chk (
  .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .chain_in(chain_in), .chain_out(chain_out),
  .act(act), .base_q(base_q), .swi_q(swi_q)
);

// File: tb/vic_chain_node_tb.sv
`timescale 1ns/1ps
module vic_chain_node_tb;
  logic        clk = 0, rst = 1;
  logic [31:0] irq_in = '0;
  logic        csr_rd = 0, csr_wr = 0;
  logic [5:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic [44:0] chain_in = '0, chain_out;

  vic_chain_node u_dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [5:0]  m_lvl [32];
  logic [5:0]  m_rs  [32];
  logic [31:0] m_nmi, m_en, m_swi, m_base;
  logic [1:0]  m_sp;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [44:0] exp_out(logic [31:0] irq, logic [44:0] ch);
    int best = -1;
    int bk = 0;
    int ck;
    for (int i = 31; i >= 0; i--)
      if ((irq[i] | m_swi[i]) && m_en[i] && m_lvl[i] != 0) begin
        int k = (m_nmi[i] ? 64 : 0) + int'(m_lvl[i]);
        if (k >= bk) begin bk = k; best = i; end
      end
    ck = (ch[5:0] == 0) ? 0 : ((ch[6] ? 64 : 0) + int'(ch[5:0]));
    if (best >= 0 && bk > ck)
      return {m_base + (32'(best) << (4 + m_sp)), m_rs[best], m_nmi[best], m_lvl[best]};
    return ch;
  endfunction

  function automatic logic [31:0] exp_rd(logic [5:0] a);
    if (a < 32) return {18'b0, m_en[a], m_nmi[a], m_rs[a], m_lvl[a]};
    if (a == 6'h20) return m_swi;
    if (a == 6'h21) return m_base;
    if (a == 6'h22) return {30'b0, m_sp};
    return '0;
  endfunction

  task automatic csr_write(input logic [5:0] a, input logic [31:0] d);
    csr_wr = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 0;
    if (a < 32) begin
      m_lvl[a] = d[5:0]; m_rs[a] = d[11:6]; m_nmi[a] = d[12]; m_en[a] = d[13];
    end
    if (a == 6'h20) m_swi = d;
    if (a == 6'h21) m_base = d;
    if (a == 6'h22) m_sp = d[1:0];
  endtask

  task automatic cfg(input int i, input logic [5:0] lvl, input logic [5:0] rs, input bit nmi, input bit en);
    csr_write(6'(i), {18'b0, en, nmi, rs, lvl});
  endtask

  task automatic csr_read_chk(input logic [5:0] a, input string tag);
    csr_rd = 1; csr_addr = a;
    @(negedge clk);
    csr_rd = 0;
    chk(csr_rdata == exp_rd(a), tag, 64'(csr_rdata), 64'(exp_rd(a)));
  endtask

  task automatic step(input logic [31:0] irq, input logic [44:0] ch, input string tag);
    logic [44:0] e;
    irq_in = irq; chain_in = ch;
    e = exp_out(irq, ch);
    @(negedge clk);
    chk(chain_out == e, tag, 64'(chain_out), 64'(e));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int s;
    logic [44:0] prev, e;
    s = $urandom(32'd2024);
    for (int i = 0; i < 32; i++) begin m_lvl[i] = 0; m_rs[i] = 0; end
    m_nmi = 0; m_en = 0; m_swi = 0; m_base = 0; m_sp = 0;
    repeat (3) @(negedge clk);
    chk(chain_out == '0, "R1 output during reset", 64'(chain_out), 0);
    rst = 0;
    @(negedge clk);
    chk(chain_out == '0, "R1 output after reset", 64'(chain_out), 0);
    csr_read_chk(6'd5, "R1 config clear");
    csr_read_chk(6'h21, "R1 base clear");
    step(32'hFFFF_FFFF, '0, "R8 all lines high, none enabled");

    csr_write(6'h21, 32'h0000_1000);
    csr_write(6'h22, 32'hFFFF_FFF1);
    cfg(3, 6'd10, 6'd5, 0, 1);
    cfg(7, 6'd10, 6'd9, 0, 1);
    csr_read_chk(6'h22, "R11 spacing readback");
    csr_read_chk(6'd7, "R11 config readback");
    step(32'h88, '0, "R3 tie to lowest index");
    chk(chain_out[44:13] == 32'h1060, "R6 handler 0x1000+3*32", 64'(chain_out[44:13]), 64'h1060);
    chk(chain_out[12:7] == 6'd5 && chain_out[6] == 0 && chain_out[5:0] == 6'd10,
        "R2 field layout", 64'(chain_out[12:0]), 64'({6'd5, 1'b0, 6'd10}));
    cfg(20, 6'd1, 6'd2, 1, 1);
    step(32'h0010_0088, '0, "R4 NMI level 1 beats level 10");
    step(32'h88, {32'hABCD_0000, 6'd1, 1'b0, 6'd10}, "R5 equal chain level kept");
    step(32'h88, {32'hABCD_0000, 6'd1, 1'b0, 6'd9}, "R5 lower chain level replaced");
    step(32'h0010_0000, {32'h1234_5678, 6'd3, 1'b1, 6'd1}, "R5 chain NMI tie kept");
    step(32'h88, {32'h1234_5678, 6'd3, 1'b1, 6'd0}, "R5 chain level 0 is no request");
    cfg(9, 6'd63, 6'd1, 1, 0);
    step(32'h200, '0, "R8 disabled NMI line ignored");
    for (int sp = 0; sp < 4; sp++) begin
      csr_write(6'h22, 32'(sp));
      step(32'h80, '0, "R6 spacing code");
    end
    csr_write(6'h20, 32'h0000_0008);
    step(32'h0, '0, "R9 software interrupt raises line 3");
    csr_read_chk(6'h20, "R9 software register readback");
    csr_write(6'h20, 32'h0);
    step(32'h0, '0, "R9 software interrupt cleared");

    prev = chain_out;
    irq_in = 32'h8;
    #1 chk(chain_out == prev, "R7 no change before edge", 64'(chain_out), 64'(prev));
    step(32'h8, '0, "R7 change one clock later");

    csr_wr = 1; csr_addr = 6'd3; csr_wdata = {18'b0, 1'b1, 1'b0, 6'd4, 6'd40};
    e = chain_out;
    @(negedge clk);
    csr_wr = 0;
    m_lvl[3] = 6'd40; m_rs[3] = 6'd4; m_en[3] = 1;
    chk(chain_out == e, "R10 output not yet updated at write edge", 64'(chain_out), 64'(e));
    step(32'h8, '0, "R10 written config used next cycle");

    for (int it = 0; it < 600; it++) begin
      int r = $urandom % 16;
      if (r < 3) cfg($urandom % 32, 6'($urandom), 6'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 != 0));
      else if (r == 3) csr_write(6'h21, $urandom & 32'hFFFF_FFF0);
      else if (r == 4) csr_write(6'h22, $urandom);
      else if (r == 5) csr_write(6'h20, $urandom & $urandom & $urandom);
      else if (r == 6) csr_read_chk(6'($urandom % 40), "R11 random readback");
      step($urandom & $urandom,
           ($urandom % 3 == 0) ? '0 : {$urandom, 6'($urandom), 1'($urandom % 5 == 0), 6'($urandom)},
           "R3 R4 R5 random record");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule